// File: doc/BRIEF.md
# Programmable Mux-Select Frequency Generator Bank

This block holds six clock frequency generators. Each generator takes one of three fast source clocks, divides it by a programmed ratio and drives one output clock. The output can also be gated off. All settings sit in two 32-bit control registers. Register A holds generators 0 to 2 and register B holds generators 3 to 5, each generator in its own 10-bit field. Software loads a whole register through a simple write port, or turns single generators on and off through per-generator command strobes.

A static mode pin picks one of two register-compatible encodings. Legacy mode has a one-bit source select, a separate enable bit and even ratios only. Extended mode has a two-bit source code in which code 0 means off. A per-register scale bit in extended mode also allows odd ratios. Source clocks are treated as level signals and sampled by the block clock, which must run at least twice as fast as any source. Each source half-period then becomes one count event. A generator with ratio R holds its output high for R source half-periods and low for R source half-periods. Changes of source or ratio are applied only as a low phase begins, so the output never shows a shortened pulse.

Each generator runs a small state machine with three states. GS_OFF holds the output low. GS_LOW counts R events, then moves to GS_HIGH. GS_HIGH counts R events and then takes one of two paths. If the generator is still wanted on, it loads the current source and ratio and moves to GS_LOW. If it is no longer wanted, it moves to GS_OFF. From GS_OFF, a wanted-on setting loads the source and ratio and enters GS_LOW.

Top module: `fgen_bank`

## Requirements
- R1: Generator g uses register A when g < 3 and register B otherwise. Its field starts at bit 10×(g mod 3). Field bits 9:2 hold the divider code N. A write with wr_en high loads the whole register chosen by wr_sel (0 = A, 1 = B) at the next clock edge. cfg_a and cfg_b always show the register contents.
- R2: In legacy mode (ext_mode low), field bit 0 selects the source (0 = src_cpu, 1 = src_aux) and field bit 1 turns the generator on. The ratio is 2×(N+1).
- R3: In extended mode, field bits 1:0 form the source code: 0 = off, 1 = src_aux2, 2 = src_cpu, 3 = src_aux. A generator whose code is 0 ends with its output held low.
- R4: In extended mode, bit 30 of a register is the scale bit for the three generators in that register. When it is set the ratio is N+1; when it is clear the ratio is 2×(N+1). Legacy mode ignores bit 30.
- R5: With ratio R on a source toggling every h block clocks, the output stays high for exactly R×h clocks and low for R×h clocks. Odd ratios therefore keep the duty within one source half-period of 50%, and ratio 1 follows the source.
- R6: A dis_cmd bit clears field bit 1 in legacy mode, or writes code 0 in extended mode. An en_cmd bit sets field bit 1 in legacy mode, or restores the last non-zero code written to that field in extended mode. When both are set for one generator, disable wins. In a cycle with wr_en high, all commands are ignored.
- R7: A new source, ratio or on/off setting takes effect only at the end of a high phase, or while the generator is off. A running high phase always completes at its old length.
- R8: Each source passes through two sampling registers. An output moves one clock after the second register sees a source transition, and only then.
- R9: A synchronous reset clears both registers, sets every stored restore code to 1 and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode | input | 1 | 0 = legacy encoding, 1 = extended encoding |
| src_cpu | input | 1 | CPU PLL source clock (level) |
| src_aux | input | 1 | Auxiliary PLL source clock (level) |
| src_aux2 | input | 1 | Second auxiliary PLL source clock (level) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = A, 1 = B |
| wr_data | input | 32 | Register write data |
| en_cmd | input | 6 | Per-generator turn-on command |
| dis_cmd | input | 6 | Per-generator turn-off command |
| cfg_a | output | 32 | Contents of register A |
| cfg_b | output | 32 | Contents of register B |
| gen_clk | output | 6 | Generator output clocks |

## Verification
The three sources toggle every 2, 3 and 5 block clocks. This makes a wrong source selection show up as a wrong output period. Ratios 2, 4 and 12 are set in legacy mode, with the scale bit set so that any leak of it would halve the period. In extended mode the ratios are 1, 3, 4 and 6, with the scale bit set and then cleared. These separate even from odd ratios, pass-through from division and a scaled from an unscaled divider. Commands that disable and re-enable a generator, collide with a write, or arrive just after reset show whether the restore code is kept correctly. A ratio change made in mid high phase shows whether the update waits for the low phase. A behavioural model compares every output and both registers on every clock.

// File: rtl/fgen_pkg.sv
package fgen_pkg;
    localparam int NUM_SRC = 3;
    localparam int SRC_W   = 2;

    typedef enum logic [1:0] {
        GS_OFF  = 2'd0,
        GS_LOW  = 2'd1,
        GS_HIGH = 2'd2
    } gen_state_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_CPU  = 2'd0,
        SRC_AUX  = 2'd1,
        SRC_AUX2 = 2'd2
    } src_sel_e;
endpackage

// File: rtl/fgen_srcsync.sv
module fgen_srcsync
    import fgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    output logic [NUM_SRC-1:0] tick
);
    logic [NUM_SRC-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= src;
            s2_q <= s1_q;
        end
    end

    // one event per sampled source half-period
    assign tick = s1_q ^ s2_q;
endmodule

// File: rtl/fgen_cfgregs.sv
module fgen_cfgregs
    import fgen_pkg::*;
#(
    parameter int NGEN      = 6,
    parameter int PER_REG   = 3,
    parameter int FIELD_W   = 10,
    parameter int REG_W     = 32,
    parameter int SCALE_BIT = 30,
    parameter int DIV_W     = FIELD_W - 2,
    parameter int RATIO_W   = DIV_W + 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ext_mode,
    input  logic                          wr_en,
    input  logic                          wr_sel,
    input  logic [REG_W-1:0]              wr_data,
    input  logic [NGEN-1:0]               en_cmd,
    input  logic [NGEN-1:0]               dis_cmd,
    output logic [REG_W-1:0]              cfg_a,
    output logic [REG_W-1:0]              cfg_b,
    output logic [NGEN-1:0]               want_on,
    output logic [NGEN-1:0][SRC_W-1:0]    want_src,
    output logic [NGEN-1:0][RATIO_W-1:0]  want_ratio
);
    localparam int NREG = (NGEN + PER_REG - 1) / PER_REG;

    logic [REG_W-1:0]           regs_q [NREG];
    logic [REG_W-1:0]           regs_d [NREG];
    logic [NGEN-1:0][1:0]       shd_q, shd_d;

    always_comb begin
        regs_d = regs_q;
        shd_d  = shd_q;
        if (wr_en) begin
            regs_d[wr_sel] = wr_data;
            for (int g = 0; g < NGEN; g++) begin
                if ((g / PER_REG) == int'(wr_sel) &&
                    wr_data[FIELD_W*(g%PER_REG) +: 2] != 2'd0)
                    shd_d[g] = wr_data[FIELD_W*(g%PER_REG) +: 2];
            end
        end else begin
            for (int g = 0; g < NGEN; g++) begin
                if (dis_cmd[g]) begin
                    if (ext_mode) regs_d[g/PER_REG][FIELD_W*(g%PER_REG) +: 2] = 2'd0;
                    else          regs_d[g/PER_REG][FIELD_W*(g%PER_REG) + 1]  = 1'b0;
                end else if (en_cmd[g]) begin
                    if (ext_mode) regs_d[g/PER_REG][FIELD_W*(g%PER_REG) +: 2] = shd_q[g];
                    else          regs_d[g/PER_REG][FIELD_W*(g%PER_REG) + 1]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
            for (int g = 0; g < NGEN; g++) shd_q[g] <= 2'd1;
        end else begin
            for (int r = 0; r < NREG; r++) regs_q[r] <= regs_d[r];
            shd_q <= shd_d;
        end
    end

    assign cfg_a = regs_q[0];
    assign cfg_b = regs_q[NREG-1];

    for (genvar g = 0; g < NGEN; g++) begin : g_dec
        localparam int RI  = g / PER_REG;
        localparam int OFF = FIELD_W * (g % PER_REG);
        logic [FIELD_W-1:0] fld;
        logic [RATIO_W-1:0] base;
        logic               scl;

        assign fld  = regs_q[RI][OFF +: FIELD_W];
        assign scl  = regs_q[RI][SCALE_BIT];
        assign base = RATIO_W'(fld[FIELD_W-1:2]) + RATIO_W'(1);

        assign want_on[g]    = ext_mode ? (fld[1:0] != 2'd0) : fld[1];
        assign want_src[g]   = ext_mode ?
                               ((fld[1:0] == 2'd1) ? SRC_AUX2 :
                                (fld[1:0] == 2'd3) ? SRC_AUX  : SRC_CPU) :
                               (fld[0] ? SRC_AUX : SRC_CPU);
        assign want_ratio[g] = (ext_mode && scl) ? base : (base << 1);
    end
endmodule

// File: rtl/fgen_gen.sv
module fgen_gen
    import fgen_pkg::*;
#(
    parameter int RATIO_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] tick,
    input  logic               want_on,
    input  logic [SRC_W-1:0]   want_src,
    input  logic [RATIO_W-1:0] want_ratio,
    output logic               gclk
);
    localparam int PAD = (1 << SRC_W) - NUM_SRC;

    gen_state_e         st_q, st_d;
    logic [SRC_W-1:0]   src_q, src_d;
    logic [RATIO_W-1:0] rat_q, rat_d, cnt_q, cnt_d;
    logic [(1<<SRC_W)-1:0] tick_pad;
    logic               ev, last;

    assign tick_pad = {{PAD{1'b0}}, tick};
    assign ev       = tick_pad[src_q];
    assign last     = (cnt_q == rat_q - RATIO_W'(1));

    always_comb begin
        st_d  = st_q;
        src_d = src_q;
        rat_d = rat_q;
        cnt_d = cnt_q;
        unique case (st_q)
            GS_OFF: begin
                if (want_on) begin
                    st_d  = GS_LOW;
                    src_d = want_src;
                    rat_d = want_ratio;
                    cnt_d = '0;
                end
            end
            GS_LOW: begin
                if (ev) begin
                    if (last) begin
                        cnt_d = '0;
                        st_d  = GS_HIGH;
                    end else begin
                        cnt_d = cnt_q + RATIO_W'(1);
                    end
                end
            end
            GS_HIGH: begin
                if (ev) begin
                    if (last) begin
                        cnt_d = '0;
                        if (want_on) begin
                            st_d  = GS_LOW;
                            src_d = want_src;
                            rat_d = want_ratio;
                        end else begin
                            st_d = GS_OFF;
                        end
                    end else begin
                        cnt_d = cnt_q + RATIO_W'(1);
                    end
                end
            end
            default: st_d = GS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= GS_OFF;
            src_q <= '0;
            rat_q <= RATIO_W'(2);
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            src_q <= src_d;
            rat_q <= rat_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb gclk = (st_q == GS_HIGH);
endmodule

// File: rtl/fgen_bank.sv
module fgen_bank
    import fgen_pkg::*;
#(
    parameter int NGEN      = 6,
    parameter int PER_REG   = 3,
    parameter int FIELD_W   = 10,
    parameter int REG_W     = 32,
    parameter int SCALE_BIT = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_mode,
    input  logic             src_cpu,
    input  logic             src_aux,
    input  logic             src_aux2,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [NGEN-1:0]  en_cmd,
    input  logic [NGEN-1:0]  dis_cmd,
    output logic [REG_W-1:0] cfg_a,
    output logic [REG_W-1:0] cfg_b,
    output logic [NGEN-1:0]  gen_clk
);
    localparam int DIV_W   = FIELD_W - 2;
    localparam int RATIO_W = DIV_W + 2;

    logic [NUM_SRC-1:0]              tick;
    logic [NGEN-1:0]                 want_on;
    logic [NGEN-1:0][SRC_W-1:0]      want_src;
    logic [NGEN-1:0][RATIO_W-1:0]    want_ratio;

    fgen_srcsync u_sync (
        .clk  (clk),
        .rst  (rst),
        .src  ({src_aux2, src_aux, src_cpu}),
        .tick (tick)
    );

    fgen_cfgregs #(
        .NGEN      (NGEN),
        .PER_REG   (PER_REG),
        .FIELD_W   (FIELD_W),
        .REG_W     (REG_W),
        .SCALE_BIT (SCALE_BIT),
        .DIV_W     (DIV_W),
        .RATIO_W   (RATIO_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ext_mode   (ext_mode),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .en_cmd     (en_cmd),
        .dis_cmd    (dis_cmd),
        .cfg_a      (cfg_a),
        .cfg_b      (cfg_b),
        .want_on    (want_on),
        .want_src   (want_src),
        .want_ratio (want_ratio)
    );

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        fgen_gen #(.RATIO_W(RATIO_W)) u_gen (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .want_on    (want_on[g]),
            .want_src   (want_src[g]),
            .want_ratio (want_ratio[g]),
            .gclk       (gen_clk[g])
        );
    end
endmodule

// File: rtl/fgen_bank_chk.sv
module fgen_bank_chk #(
    parameter int NGEN  = 6,
    parameter int REG_W = 32,
    parameter int NSRC  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_mode,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [REG_W-1:0] wr_data,
    input logic [NGEN-1:0]  en_cmd,
    input logic [NGEN-1:0]  dis_cmd,
    input logic [REG_W-1:0] cfg_a,
    input logic [REG_W-1:0] cfg_b,
    input logic [NGEN-1:0]  gen_clk,
    input logic [NSRC-1:0]  tick
);
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (gen_clk == '0 && cfg_a == '0 && cfg_b == '0));

    assert_write_load_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> (cfg_a == $past(wr_data)));

    assert_ext_off_R6: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && !wr_en && dis_cmd[0]) |=> (cfg_a[1:0] == 2'd0));

    assert_ext_restore_R6: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && !wr_en && en_cmd[0] && !dis_cmd[0]) |=> (cfg_a[1:0] != 2'd0));

    assert_legacy_on_R2: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && !wr_en && en_cmd[3] && !dis_cmd[3]) |=> cfg_b[1]);

    assert_moves_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(gen_clk) |-> $past(|tick));
endmodule

bind fgen_bank fgen_bank_chk #(.NGEN(NGEN), .REG_W(REG_W), .NSRC(3)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_mode (ext_mode),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .en_cmd   (en_cmd),
    .dis_cmd  (dis_cmd),
    .cfg_a    (cfg_a),
    .cfg_b    (cfg_b),
    .gen_clk  (gen_clk),
    .tick     (tick)
);

// File: tb/tb_fgen_bank.sv
`timescale 1ns/1ps
module tb_fgen_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_mode = 1'b0;
    logic        src_cpu = 1'b0, src_aux = 1'b0, src_aux2 = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [5:0]  en_cmd = '0, dis_cmd = '0;
    logic [31:0] cfg_a, cfg_b;
    logic [5:0]  gen_clk;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  chk_on = 1'b0;
    bit  done = 1'b0;
    string cur_req = "R8";

    always #2.5 clk = ~clk;

    fgen_bank dut (
        .clk(clk), .rst(rst), .ext_mode(ext_mode),
        .src_cpu(src_cpu), .src_aux(src_aux), .src_aux2(src_aux2),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .cfg_a(cfg_a), .cfg_b(cfg_b), .gen_clk(gen_clk)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // sources: cpu toggles every 2 clocks, aux every 3, aux2 every 5
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc % 2 == 0) src_cpu  = ~src_cpu;
            if (cyc % 3 == 0) src_aux  = ~src_aux;
            if (cyc % 5 == 0) src_aux2 = ~src_aux2;
        end
    end

    // behavioural reference model
    int          mst [6];
    int          msrc[6];
    int          mrat[6];
    int          mcnt[6];
    logic [31:0] mreg[2];
    logic [1:0]  mshd[6];
    logic [2:0]  ms1, ms2;
    logic [5:0]  mout;

    always @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < 6; g++) begin
                mst[g] = 0; msrc[g] = 0; mrat[g] = 2; mcnt[g] = 0; mshd[g] = 2'd1;
            end
            mreg[0] = '0; mreg[1] = '0; ms1 = '0; ms2 = '0;
        end else begin
            for (int g = 0; g < 6; g++) begin
                int fld, n, code, on, src, rat, sh;
                bit ev;
                sh   = 10 * (g % 3);
                fld  = int'((mreg[g/3] >> sh) & 32'h3ff);
                n    = fld >> 2;
                code = fld & 3;
                if (!ext_mode) begin
                    on = (fld >> 1) & 1; src = fld & 1; rat = 2 * (n + 1);
                end else begin
                    on  = (code != 0);
                    src = (code == 1) ? 2 : (code == 3) ? 1 : 0;
                    rat = mreg[g/3][30] ? (n + 1) : 2 * (n + 1);
                end
                ev = ms1[msrc[g]] ^ ms2[msrc[g]];
                if (mst[g] == 0) begin
                    if (on != 0) begin mst[g] = 1; msrc[g] = src; mrat[g] = rat; mcnt[g] = 0; end
                end else if (ev) begin
                    if (mcnt[g] == mrat[g] - 1) begin
                        mcnt[g] = 0;
                        if (mst[g] == 1) mst[g] = 2;
                        else if (on != 0) begin mst[g] = 1; msrc[g] = src; mrat[g] = rat; end
                        else mst[g] = 0;
                    end else mcnt[g]++;
                end
            end
            if (wr_en) begin
                mreg[wr_sel] = wr_data;
                for (int g = 0; g < 6; g++)
                    if ((g / 3) == int'(wr_sel) && ((wr_data >> (10*(g%3))) & 3) != 0)
                        mshd[g] = 2'((wr_data >> (10*(g%3))) & 3);
            end else begin
                for (int g = 0; g < 6; g++) begin
                    int sh;
                    sh = 10 * (g % 3);
                    if (dis_cmd[g]) begin
                        if (ext_mode) mreg[g/3] = mreg[g/3] & ~(32'h3 << sh);
                        else          mreg[g/3] = mreg[g/3] & ~(32'h2 << sh);
                    end else if (en_cmd[g]) begin
                        if (ext_mode) mreg[g/3] = (mreg[g/3] & ~(32'h3 << sh)) | (32'(mshd[g]) << sh);
                        else          mreg[g/3] = mreg[g/3] | (32'h2 << sh);
                    end
                end
            end
            ms2 = ms1;
            ms1 = {src_aux2, src_aux, src_cpu};
        end
        for (int g = 0; g < 6; g++) mout[g] = (mst[g] == 2);
    end

    // cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (chk_on) begin
            check(gen_clk === mout, cur_req, "gen_clk vs model", gen_clk, mout);
            check(cfg_a === mreg[0], "R1", "cfg_a vs model", cfg_a, mreg[0]);
            check(cfg_b === mreg[1], "R1", "cfg_b vs model", cfg_b, mreg[1]);
        end
    end

    task automatic write_reg(bit sel, logic [31:0] data, logic [5:0] en = '0, logic [5:0] dis = '0);
        wr_en = 1'b1; wr_sel = sel; wr_data = data; en_cmd = en; dis_cmd = dis;
        @(negedge clk);
        wr_en = 1'b0; en_cmd = '0; dis_cmd = '0;
    endtask

    task automatic command(logic [5:0] en, logic [5:0] dis);
        en_cmd = en; dis_cmd = dis;
        @(negedge clk);
        en_cmd = '0; dis_cmd = '0;
    endtask

    task automatic measure(int g, int exp_per, int exp_hi, string req);
        int t, hi, per;
        t = 0;
        while (gen_clk[g] !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
        while (gen_clk[g] !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
        hi = 0;
        while (gen_clk[g] === 1'b1 && hi < 3000) begin @(negedge clk); hi++; end
        per = hi;
        while (gen_clk[g] === 1'b0 && per < 6000) begin @(negedge clk); per++; end
        check(hi == exp_hi, req, $sformatf("gen%0d high time", g), hi, exp_hi);
        check(per == exp_per, req, $sformatf("gen%0d period", g), per, exp_per);
    endtask

    task automatic stays_low(int g, int cycles, string req);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (gen_clk[g] !== 1'b0) seen++;
        end
        check(seen == 0, req, $sformatf("gen%0d held low", g), seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(cfg_a === 32'h0 && cfg_b === 32'h0, "R9", "registers after reset", cfg_a, 0);
        check(gen_clk === 6'h0, "R9", "outputs after reset", gen_clk, 0);
        chk_on = 1'b1;

        // R9 / R6: restore code after reset is 1
        ext_mode = 1'b1;
        command(6'b000010, 6'b0);
        check(cfg_a[11:10] === 2'd1, "R9", "restore code after reset", cfg_a[11:10], 1);
        write_reg(1'b0, 32'h0);
        repeat (30) @(negedge clk);
        ext_mode = 1'b0;

        // R2 / R4: legacy encodings, scale bit set but ignored
        write_reg(1'b0, 32'd2 | (32'd7 << 10) | (32'd21 << 20) | (32'd1 << 30));
        check(cfg_a === (32'd2 | (32'd7 << 10) | (32'd21 << 20) | (32'd1 << 30)),
              "R1", "register A readback", cfg_a, 0);
        measure(0, 8, 4, "R2");
        measure(1, 24, 12, "R4");
        stays_low(2, 60, "R2");
        command(6'b000100, 6'b0);
        check(cfg_a[21] === 1'b1, "R6", "legacy enable bit set", cfg_a[21], 1);
        measure(2, 72, 36, "R2");
        command(6'b0, 6'b000001);
        check(cfg_a[1] === 1'b0, "R6", "legacy enable bit cleared", cfg_a[1], 0);
        repeat (10) @(negedge clk);
        stays_low(0, 40, "R7");

        // R3 / R4 / R5: extended mode, scale set
        ext_mode = 1'b1;
        write_reg(1'b1, 32'd11 | (32'd1 << 10) | (32'd14 << 20) | (32'd1 << 30));
        measure(3, 18, 9, "R5");
        measure(4, 10, 5, "R5");
        measure(5, 16, 8, "R4");

        // R7: ratio change during a high phase keeps the current high length
        begin
            int hi, lo, t;
            t = 0;
            while (gen_clk[5] !== 1'b0 && t < 200) begin @(negedge clk); t++; end
            while (gen_clk[5] !== 1'b1 && t < 200) begin @(negedge clk); t++; end
            hi = 1;
            write_reg(1'b1, 32'd11 | (32'd1 << 10) | (32'd2 << 20) | (32'd1 << 30));
            while (gen_clk[5] === 1'b1 && hi < 200) begin @(negedge clk); hi++; end
            lo = 0;
            while (gen_clk[5] === 1'b0 && lo < 200) begin @(negedge clk); lo++; end
            check(hi == 8, "R7", "high phase kept at old length", hi, 8);
            check(lo == 2, "R7", "low phase uses new ratio", lo, 2);
        end

        // R4: scale cleared doubles the ratio
        write_reg(1'b1, 32'd11 | (32'd1 << 10) | (32'd14 << 20));
        measure(3, 36, 18, "R4");

        // R6 / R3: disable and restore in extended mode
        command(6'b0, 6'b001000);
        check(cfg_b[1:0] === 2'd0, "R6", "extended disable code", cfg_b[1:0], 0);
        repeat (40) @(negedge clk);
        stays_low(3, 40, "R3");
        command(6'b001000, 6'b0);
        check(cfg_b[1:0] === 2'd3, "R6", "restored source code", cfg_b[1:0], 3);
        measure(3, 36, 18, "R6");

        // R6: disable wins over enable
        command(6'b010000, 6'b010000);
        check(cfg_b[11:10] === 2'd0, "R6", "disable wins", cfg_b[11:10], 0);

        // R6: write takes precedence over commands
        write_reg(1'b1, 32'd11 | (32'd1 << 10) | (32'd14 << 20), 6'b0, 6'b001000);
        check(cfg_b === (32'd11 | (32'd1 << 10) | (32'd14 << 20)), "R6",
              "commands ignored during write", cfg_b, 0);

        // R3: code 0 written directly turns a generator off
        write_reg(1'b1, 32'd11 | (32'd14 << 20));
        repeat (20) @(negedge clk);
        stays_low(4, 40, "R3");

        repeat (50) @(negedge clk);
        done = 1'b1;
        chk_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule